// File: doc/BRIEF.md
# Prioritized Channel Interrupt Controller

This block gathers 32 system interrupt lines and presents them to a processor as two host interrupt outputs. Each line is captured into a sticky pending bit. Capture is either level-sensitive or edge-triggered, and each line has its own active sense. A pending line that is enabled is routed to one of 32 priority channels through a table that holds one byte per line. The channel number sets the line's rank: channel 0 ranks highest. It also picks the host output. Channels 0 and 1 feed the fast output, and channels 2 to 31 feed the normal output.

Software reaches the block over a simple register bus with separate read and write strobes, a word address and 32-bit data. Enables and pending bits can be changed one line at a time, by writing a line number to an index register, or as a whole word through write-one-to-clear registers. Each host output has a read-only index register. It names the best pending line for that output, so an interrupt handler can find its source with a single read.

Top module: `prio_chan_intc`

## Requirements
- R1: After reset, the following are all zero and both host outputs are low: the global enable, both host enables, every line enable, every pending bit, every sense bit and every mode bit. Every channel-table byte reads 0x0F.
- R2: Writing a line number to EN_IDX_SET (word 0x06) enables only that line. Writing it to EN_IDX_CLR (word 0x07) disables only that line. An index with any bit set above bit 4 changes nothing. The enable word reads at 0x04.
- R3: Writing a line number to PEND_IDX_CLR (word 0x03) clears only that line's pending bit. An index above 31 changes nothing. The pending word reads at 0x01.
- R4: Writing a word to PEND_CLR (word 0x02) or EN_CLR (word 0x05) clears every pending bit or enable bit that is written as 1, and leaves the others unchanged.
- R5: In level mode (mode bit 0), a pending bit is set in the cycle after its input is at the active level. The active level is high when the sense bit is 1 and low when it is 0. The bit stays set after the input goes inactive. A clear that arrives while the input is still active loses to the capture. Sense bits are at word 0x0B and mode bits at word 0x0C.
- R6: In edge mode (mode bit 1), a pending bit is set in the cycle after the input moves to its active level: a rising edge for sense 1, a falling edge for sense 0. An input that is held at the active level does not set the bit again once it has been cleared.
- R7: Channel-table word 0x10+k holds lines 4k to 4k+3, one byte each, with the lowest byte belonging to the lowest line. The byte value is the channel number. A byte of 32 or more routes the line nowhere.
- R8: Among the pending, enabled lines on one host output, the line on the lowest channel number wins. When two lines share a channel, the lower line number wins.
- R9: Lines on channels 0 to 1 drive only fastIrq. Lines on channels 2 to 31 drive only normIrq.
- R10: A host output is high only when three things hold: the global enable (word 0x00, bit 0) is 1, that output's host enable is 1, and a line is routed to it. Writing 0 or 1 to HOST_IDX_SET (word 0x09) or HOST_IDX_CLR (word 0x0A) sets or clears the fast or normal host enable. Any other index is ignored. The host enables read at 0x08, with the fast enable in bit 0.
- R11: The index registers for fast (word 0x0D) and normal (word 0x0E) read the winning line number in bits 4:0 and 0 in bit 31. When no line wins they read 0x8000_0000. The global and host enables do not affect them.
- R12: A read returns its data on rdata one clock after the cycle in which rdEn is high. Write-only addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irqIn | input | 32 | System interrupt lines |
| fastIrq | output | 1 | Fast host interrupt |
| normIrq | output | 1 | Normal host interrupt |

## Verification
On every cycle the assertions check the following. A single-index write changes at most one enable or pending bit. An edge-mode pending bit rises only after its input has changed. A reported winner is really pending and enabled. Neither host output is high while the global enable is off. The bench scenarios cover the rest, which no per-cycle property can show: the rank order between channels, the tie-break by line number, which host output a channel selects, the byte order of the channel table, the stickiness and set-over-clear behaviour of level capture, and that out-of-range indices and channel values change nothing.

// File: rtl/pcic_pkg.sv
package pcic_pkg;
  localparam int IRQ_N = 32;
  localparam int CHAN_N = 32;
  localparam int FAST_CHANS = 2;
  localparam int HOST_N = 2;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int IDX_W = $clog2(IRQ_N);
  localparam int BYTES_PER_MAP = 4;
  localparam int MAP_REGS = IRQ_N / BYTES_PER_MAP;
  localparam int MAP_SEL_W = $clog2(MAP_REGS);
  localparam logic [7:0] DEFAULT_CHAN = 8'h0F;

  localparam logic [ADDR_W-1:0] A_GLOBAL       = 6'h00;
  localparam logic [ADDR_W-1:0] A_PEND         = 6'h01;
  localparam logic [ADDR_W-1:0] A_PEND_CLR     = 6'h02;
  localparam logic [ADDR_W-1:0] A_PEND_IDX_CLR = 6'h03;
  localparam logic [ADDR_W-1:0] A_EN           = 6'h04;
  localparam logic [ADDR_W-1:0] A_EN_CLR       = 6'h05;
  localparam logic [ADDR_W-1:0] A_EN_IDX_SET   = 6'h06;
  localparam logic [ADDR_W-1:0] A_EN_IDX_CLR   = 6'h07;
  localparam logic [ADDR_W-1:0] A_HOST         = 6'h08;
  localparam logic [ADDR_W-1:0] A_HOST_IDX_SET = 6'h09;
  localparam logic [ADDR_W-1:0] A_HOST_IDX_CLR = 6'h0A;
  localparam logic [ADDR_W-1:0] A_SENSE        = 6'h0B;
  localparam logic [ADDR_W-1:0] A_MODE         = 6'h0C;
  localparam logic [ADDR_W-1:0] A_WIN_FAST     = 6'h0D;
  localparam logic [ADDR_W-1:0] A_WIN_NORM     = 6'h0E;
  localparam logic [ADDR_W-1:0] A_MAP_BASE     = 6'h10;

  typedef enum logic [3:0] {
    RS_ZERO, RS_GLOBAL, RS_PEND, RS_EN, RS_HOST, RS_SENSE, RS_MODE,
    RS_WIN_FAST, RS_WIN_NORM, RS_MAP
  } rd_sel_e;

  typedef struct packed {
    logic                 rdEn;
    rd_sel_e              rdSel;
    logic                 wrGlobal;
    logic                 wrPendClr;
    logic                 wrPendIdxClr;
    logic                 wrEnClr;
    logic                 wrEnIdxSet;
    logic                 wrEnIdxClr;
    logic                 wrHostSet;
    logic                 wrHostClr;
    logic                 wrSense;
    logic                 wrMode;
    logic                 wrMap;
    logic [MAP_SEL_W-1:0] mapSel;
    logic [DATA_W-1:0]    wdata;
  } strobe_t;

  function automatic int hostLo(int h);
    return (h == 0) ? 0 : FAST_CHANS;
  endfunction

  function automatic int hostHi(int h);
    return (h == 0) ? FAST_CHANS : CHAN_N;
  endfunction
endpackage

// File: rtl/pcic_ctrl.sv
module pcic_ctrl
  import pcic_pkg::*;
(
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output strobe_t           strb
);
  localparam logic [ADDR_W-1:0] MAP_END = A_MAP_BASE + ADDR_W'(MAP_REGS);

  logic             inMap;
  logic [ADDR_W-1:0] mapOff;

  assign inMap  = (addr >= A_MAP_BASE) && (addr < MAP_END);
  assign mapOff = addr - A_MAP_BASE;

  always_comb begin
    strb = '0;
    strb.rdEn  = rdEn;
    strb.wdata = wdata;
    strb.mapSel = mapOff[MAP_SEL_W-1:0];
    strb.rdSel = RS_ZERO;
    if (inMap) begin
      strb.rdSel = RS_MAP;
      strb.wrMap = wrEn;
    end else begin
      case (addr)
        A_GLOBAL:       begin strb.rdSel = RS_GLOBAL; strb.wrGlobal = wrEn; end
        A_PEND:         strb.rdSel = RS_PEND;
        A_PEND_CLR:     strb.wrPendClr = wrEn;
        A_PEND_IDX_CLR: strb.wrPendIdxClr = wrEn;
        A_EN:           strb.rdSel = RS_EN;
        A_EN_CLR:       strb.wrEnClr = wrEn;
        A_EN_IDX_SET:   strb.wrEnIdxSet = wrEn;
        A_EN_IDX_CLR:   strb.wrEnIdxClr = wrEn;
        A_HOST:         strb.rdSel = RS_HOST;
        A_HOST_IDX_SET: strb.wrHostSet = wrEn;
        A_HOST_IDX_CLR: strb.wrHostClr = wrEn;
        A_SENSE:        begin strb.rdSel = RS_SENSE; strb.wrSense = wrEn; end
        A_MODE:         begin strb.rdSel = RS_MODE; strb.wrMode = wrEn; end
        A_WIN_FAST:     strb.rdSel = RS_WIN_FAST;
        A_WIN_NORM:     strb.rdSel = RS_WIN_NORM;
        default:        strb.rdSel = RS_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/pcic_resolver.sv
module pcic_resolver
  import pcic_pkg::*;
#(
  parameter int LO_CHAN = 0,
  parameter int HI_CHAN = FAST_CHANS
) (
  input  logic [IRQ_N-1:0]      pending,
  input  logic [IRQ_N-1:0][7:0] chanMap,
  output logic                  hit,
  output logic [IDX_W-1:0]      winIdx
);
  int bestChan;

  // Scan from the top line down so an equal channel hands the win to the lower line.
  always_comb begin
    hit = 1'b0;
    winIdx = '0;
    bestChan = CHAN_N;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (pending[i] && (int'(chanMap[i]) >= LO_CHAN) && (int'(chanMap[i]) < HI_CHAN)
          && (int'(chanMap[i]) <= bestChan)) begin
        hit = 1'b1;
        winIdx = IDX_W'(i);
        bestChan = int'(chanMap[i]);
      end
    end
  end
endmodule

// File: rtl/pcic_datapath.sv
module pcic_datapath
  import pcic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [IRQ_N-1:0]  irqIn,
  output logic [DATA_W-1:0] rdata,
  output logic [HOST_N-1:0] hostIrq
);
  logic [IRQ_N-1:0]      pendReg, enReg, senseReg, modeReg, inPrev;
  logic [IRQ_N-1:0][7:0] chanMap;
  logic [HOST_N-1:0]     hostEn;
  logic                  globalEn;

  logic [IRQ_N-1:0] activeLvl, edgeHit, capture, clrMask, idxOneHot, pending;
  logic [IDX_W-1:0] wIdx;
  logic             idxOk, hostIdxOk;

  assign wIdx      = strb.wdata[IDX_W-1:0];
  assign idxOk     = (strb.wdata >> IDX_W) == '0;
  assign hostIdxOk = strb.wdata < DATA_W'(HOST_N);
  assign idxOneHot = {{(IRQ_N-1){1'b0}}, 1'b1} << wIdx;

  // Capture: an input at its active level, or a fresh move onto it.
  assign activeLvl = ~(irqIn ^ senseReg);
  assign edgeHit   = (irqIn ^ inPrev) & activeLvl;
  assign capture   = (modeReg & edgeHit) | (~modeReg & activeLvl);

  assign clrMask = (strb.wrPendClr ? strb.wdata[IRQ_N-1:0] : '0)
                 | ((strb.wrPendIdxClr && idxOk) ? idxOneHot : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg <= '0;
      inPrev  <= '0;
    end else begin
      inPrev  <= irqIn;
      pendReg <= (pendReg & ~clrMask) | capture;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= '0;
      senseReg <= '0;
      modeReg  <= '0;
      globalEn <= 1'b0;
      hostEn   <= '0;
    end else begin
      if (strb.wrEnClr)              enReg <= enReg & ~strb.wdata[IRQ_N-1:0];
      if (strb.wrEnIdxSet && idxOk)  enReg <= enReg | idxOneHot;
      if (strb.wrEnIdxClr && idxOk)  enReg <= enReg & ~idxOneHot;
      if (strb.wrSense)              senseReg <= strb.wdata[IRQ_N-1:0];
      if (strb.wrMode)               modeReg <= strb.wdata[IRQ_N-1:0];
      if (strb.wrGlobal)             globalEn <= strb.wdata[0];
      if (strb.wrHostSet && hostIdxOk) hostEn[strb.wdata[0]] <= 1'b1;
      if (strb.wrHostClr && hostIdxOk) hostEn[strb.wdata[0]] <= 1'b0;
    end
  end

  // Channel table: one byte per line, four lines per word.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < IRQ_N; i++) chanMap[i] <= DEFAULT_CHAN;
    end else if (strb.wrMap) begin
      for (int b = 0; b < BYTES_PER_MAP; b++)
        chanMap[int'(strb.mapSel) * BYTES_PER_MAP + b] <= strb.wdata[8*b +: 8];
    end
  end

  assign pending = pendReg & enReg;

  logic [HOST_N-1:0]            hostHit;
  logic [HOST_N-1:0][IDX_W-1:0] hostIdx;
  logic [HOST_N-1:0][DATA_W-1:0] winWord;

  for (genvar h = 0; h < HOST_N; h++) begin : g_host
    pcic_resolver #(
      .LO_CHAN(hostLo(h)),
      .HI_CHAN(hostHi(h))
    ) u_res (
      .pending(pending),
      .chanMap(chanMap),
      .hit    (hostHit[h]),
      .winIdx (hostIdx[h])
    );
    assign winWord[h] = {~hostHit[h], {(DATA_W-1-IDX_W){1'b0}}, hostIdx[h]};
    assign hostIrq[h] = globalEn & hostEn[h] & hostHit[h];
  end

  logic [DATA_W-1:0] rdMux;
  always_comb begin
    case (strb.rdSel)
      RS_GLOBAL:   rdMux = DATA_W'(globalEn);
      RS_PEND:     rdMux = DATA_W'(pendReg);
      RS_EN:       rdMux = DATA_W'(enReg);
      RS_HOST:     rdMux = DATA_W'(hostEn);
      RS_SENSE:    rdMux = DATA_W'(senseReg);
      RS_MODE:     rdMux = DATA_W'(modeReg);
      RS_WIN_FAST: rdMux = winWord[0];
      RS_WIN_NORM: rdMux = winWord[1];
      RS_MAP:      rdMux = {chanMap[int'(strb.mapSel) * BYTES_PER_MAP + 3],
                            chanMap[int'(strb.mapSel) * BYTES_PER_MAP + 2],
                            chanMap[int'(strb.mapSel) * BYTES_PER_MAP + 1],
                            chanMap[int'(strb.mapSel) * BYTES_PER_MAP]};
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdata <= '0;
    else if (strb.rdEn) rdata <= rdMux;
  end

  assert_en_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEnIdxSet || strb.wrEnIdxClr) |=> $countones(enReg ^ $past(enReg)) <= 1);

  assert_pend_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPendIdxClr |=> $countones($past(pendReg) & ~pendReg) <= 1);

  assert_edge_needs_change_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((pendReg & ~$past(pendReg) & $past(modeReg) & ~($past(irqIn) ^ $past(inPrev))) == '0));

  assert_winner_pending_R11: assert property (@(posedge clk) disable iff (!rstN)
    hostHit[0] |-> pending[hostIdx[0]]);

  assert_quiet_without_global_R10: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> (hostIrq == '0));
endmodule

// File: rtl/prio_chan_intc.sv
module prio_chan_intc
  import pcic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [IRQ_N-1:0]  irqIn,
  output logic              fastIrq,
  output logic              normIrq
);
  strobe_t           strb;
  logic [HOST_N-1:0] hostIrq;

  pcic_ctrl u_ctrl (
    .rdEn (rdEn),
    .wrEn (wrEn),
    .addr (addr),
    .wdata(wdata),
    .strb (strb)
  );

  pcic_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .irqIn  (irqIn),
    .rdata  (rdata),
    .hostIrq(hostIrq)
  );

  assign fastIrq = hostIrq[0];
  assign normIrq = hostIrq[1];
endmodule

// File: tb/sim_prio_chan_intc.sv
`timescale 1ns/1ps
module sim_prio_chan_intc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] irqIn = 32'hFFFF_FFFF;
  logic        fastIrq, normIrq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [31:0] NONE = 32'h8000_0000;

  always #2 clk = ~clk;

  prio_chan_intc u0 (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irqIn(irqIn), .fastIrq(fastIrq), .normIrq(normIrq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdata;
  endtask

  task automatic rdChk(string tag, logic [5:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic setIn(int b, logic v);
    @(negedge clk);
    irqIn[b] = v;
    @(negedge clk);
  endtask

  task automatic testReset();
    rdChk("R1 global", 6'h00, 0);
    rdChk("R1 pending", 6'h01, 0);
    rdChk("R1 enable", 6'h04, 0);
    rdChk("R1 host", 6'h08, 0);
    rdChk("R1 sense", 6'h0B, 0);
    rdChk("R1 mode", 6'h0C, 0);
    rdChk("R1 map0", 6'h10, 32'h0F0F0F0F);
    rdChk("R1 map7", 6'h17, 32'h0F0F0F0F);
    rdChk("R12 write-only reads 0", 6'h06, 0);
    chk("R1 outputs", {30'b0, fastIrq, normIrq}, 0);
  endtask

  task automatic testSetup();
    @(negedge clk); irqIn = '0;
    wr(6'h0B, 32'hFFFF_FFFF);
    wr(6'h02, 32'hFFFF_FFFF);
    rdChk("R4 pending word clear", 6'h01, 0);
    rdChk("R1 win norm none", 6'h0E, NONE);
  endtask

  task automatic testEnables();
    wr(6'h06, 5);  rdChk("R2 idx set 5", 6'h04, 32'h20);
    wr(6'h06, 9);  rdChk("R2 idx set 9", 6'h04, 32'h220);
    wr(6'h07, 5);  rdChk("R2 idx clr 5", 6'h04, 32'h200);
    wr(6'h06, 35); rdChk("R2 out-of-range idx ignored", 6'h04, 32'h200);
    wr(6'h06, 1);
    wr(6'h05, 32'h0000_0200); rdChk("R4 enable word clear", 6'h04, 32'h2);
    wr(6'h05, 32'hFFFF_FFFF); rdChk("R4 enable clear all", 6'h04, 0);
  endtask

  task automatic testLevel();
    setIn(3, 1); setIn(4, 1);
    rdChk("R5 level high capture", 6'h01, 32'h18);
    setIn(3, 0); setIn(4, 0);
    rdChk("R5 sticky", 6'h01, 32'h18);
    wr(6'h03, 3);  rdChk("R3 idx clr only 3", 6'h01, 32'h10);
    wr(6'h03, 36); rdChk("R3 out-of-range idx ignored", 6'h01, 32'h10);
    setIn(4, 1);
    wr(6'h03, 4);  rdChk("R5 capture beats clear", 6'h01, 32'h10);
    setIn(4, 0);
    wr(6'h03, 4);  rdChk("R3 idx clr 4", 6'h01, 0);
    wr(6'h0B, ~32'h80);
    rdChk("R5 level low capture", 6'h01, 32'h80);
    setIn(7, 1);
    wr(6'h03, 7);  rdChk("R5 low sense inactive when high", 6'h01, 0);
    wr(6'h0B, 32'hFFFF_FFFF);
    setIn(7, 0);
    wr(6'h03, 7);  rdChk("R5 cleanup", 6'h01, 0);
  endtask

  task automatic testEdge();
    wr(6'h0C, 32'h400);
    setIn(10, 1);
    rdChk("R6 rising edge", 6'h01, 32'h400);
    wr(6'h03, 10);
    rdChk("R6 held level no re-set", 6'h01, 0);
    wr(6'h0C, 32'hC00);
    wr(6'h0B, ~32'h800);
    setIn(11, 1);
    rdChk("R6 rising ignored for falling sense", 6'h01, 0);
    setIn(11, 0);
    rdChk("R6 falling edge", 6'h01, 32'h800);
    setIn(10, 0);
    wr(6'h0C, 0);
    wr(6'h0B, 32'hFFFF_FFFF);
    wr(6'h02, 32'hFFFF_FFFF);
    rdChk("R6 cleanup", 6'h01, 0);
  endtask

  task automatic testRouting();
    wr(6'h00, 1); wr(6'h09, 0); wr(6'h09, 1);
    wr(6'h10, 32'h0F010F0F);
    wr(6'h11, 32'h0F050F0F);
    wr(6'h12, 32'h0F0F030F);
    wr(6'h13, 32'h0F400303);
    rdChk("R7 map readback", 6'h12, 32'h0F0F030F);
    wr(6'h06, 2); wr(6'h06, 6); wr(6'h06, 9);
    wr(6'h06, 12); wr(6'h06, 13); wr(6'h06, 14);
    setIn(6, 1); setIn(9, 1);
    chk("R9 normal line", {31'b0, normIrq}, 1);
    chk("R9 fast quiet", {31'b0, fastIrq}, 0);
    rdChk("R8 lower channel wins", 6'h0E, 9);
    rdChk("R11 fast none", 6'h0D, NONE);
    setIn(2, 1);
    chk("R9 fast line", {31'b0, fastIrq}, 1);
    rdChk("R9 fast winner", 6'h0D, 2);
    setIn(2, 0); wr(6'h03, 2);
    chk("R9 fast drops", {31'b0, fastIrq}, 0);
    setIn(13, 1);
    rdChk("R8 tie lower line", 6'h0E, 9);
    setIn(9, 0); wr(6'h03, 9);
    rdChk("R8 next winner", 6'h0E, 13);
    setIn(12, 1);
    rdChk("R8 tie 12 beats 13", 6'h0E, 12);
    setIn(12, 0); setIn(13, 0);
    wr(6'h02, 32'h3000);
    rdChk("R8 fallback channel 5", 6'h0E, 6);
    setIn(6, 0); wr(6'h03, 6);
    setIn(14, 1);
    chk("R7 big channel unrouted", {31'b0, normIrq}, 0);
    rdChk("R7 big channel no winner", 6'h0E, NONE);
  endtask

  task automatic testEnableGates();
    setIn(6, 1);
    chk("R10 normal up", {31'b0, normIrq}, 1);
    wr(6'h00, 0);
    chk("R10 global off", {31'b0, normIrq}, 0);
    rdChk("R11 index ignores global", 6'h0E, 6);
    wr(6'h00, 1);
    wr(6'h0A, 1);
    chk("R10 host off", {31'b0, normIrq}, 0);
    wr(6'h09, 7);
    rdChk("R10 bad host idx ignored", 6'h08, 32'h1);
    wr(6'h09, 1);
    chk("R10 host on", {31'b0, normIrq}, 1);
    wr(6'h07, 6);
    chk("R11 disabled line drops", {31'b0, normIrq}, 0);
    rdChk("R11 disabled line not reported", 6'h0E, NONE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSetup();
    testEnables();
    testLevel();
    testEdge();
    testRouting();
    testEnableGates();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule